// File: doc/BRIEF.md
# Sensor-Bus Slave Frame Codec

This block sits between the bit recovery of a sensor-bus slave and its device logic. It takes the received line, already sliced into one bit per bit-time strobe, finds the start of each 14-bit master request and checks the request's framing and parity. It then decides whether the request is meant for this slave and, if it is, hands the control bit and the five information bits to the device logic as a one-cycle pulse.

The device logic answers with a 4-bit word over a valid/ready handshake. The codec wraps that word in a 7-bit reply frame and shifts it out a fixed number of bit times after the request ended. A slave can be addressed by its 5-bit address alone, or, in extended mode, by its 5-bit address together with an A/B select carried in information bit I3. A communication-inhibit input, raised when the field supply sags, abandons whatever frame is in flight.

The same `tick` strobe paces reception and transmission. Ticks must be at least two clock cycles apart.

Top module: `sbus_slave_codec`

## Requirements
- R1: Idle bits (1) on `rx_bit` are skipped. The first 0 sampled on a tick is the start bit, and the next 13 ticked bits are taken as CB, A4..A0, I4..I0, PB, EB, most significant first.
- R2: A request is accepted only if the ones among CB, A4..A0, I4..I0 and PB are even in number. Otherwise it is dropped with no `req_valid` and no reply.
- R3: A request whose end bit is 0 is dropped with no `req_valid` and no reply.
- R4: With `ext_mode` low, a request matches when A4..A0 equal `my_addr`, whatever I3 holds. A request that does not match is dropped silently.
- R5: With `ext_mode` high, a request matches only when A4..A0 equal `my_addr` and I3 equals `my_sel` (0 selects the A slave, 1 the B slave).
- R6: For an accepted request, `req_valid` is high for exactly one cycle, the cycle after the end-bit tick. In that cycle `req_ctrl` carries CB (0 = data/parameter transfer, 1 = command) and `req_info` carries I4..I0.
- R7: After an accepted request, `rsp_ready` stays high until a word is taken on `rsp_valid && rsp_ready`, and goes low for good once that happens. `rsp_ready` is never high while a reply is being sent.
- R8: The reply's start bit (0) is driven from the GAP_BITS-th tick after the request's end-bit tick. It is followed, one bit per tick, by I3..I0, an even-parity bit over I3..I0 and an end bit (1). `tx_active` is high for exactly those 7 bit times. At every other time `tx_bit` is 1 and changes only after a tick.
- R9: If no word has been taken by the tick on which the reply would start, no reply is sent and the block returns to listening for requests.
- R10: While `inhibit` is high, a partly received request is discarded, a reply in progress stops within one cycle (`tx_bit` 1, `tx_active` 0), and `rsp_ready` and `req_valid` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inhibit | input | 1 | Communication inhibit, aborts transfers |
| ext_mode | input | 1 | 1 = compare the A/B select bit as well |
| my_addr | input | ADDR_W (5) | Slave address |
| my_sel | input | 1 | A/B select of this slave (0 = A, 1 = B) |
| tick | input | 1 | One-cycle strobe per bit time |
| rx_bit | input | 1 | Received line value, sampled on tick |
| req_valid | output | 1 | Accepted request pulse |
| req_ctrl | output | 1 | Control bit of the request |
| req_info | output | INFO_W (5) | Information bits I4..I0 |
| rsp_ready | output | 1 | Reply word can be taken |
| rsp_valid | input | 1 | Reply word offered |
| rsp_info | input | INFO_W-1 (4) | Reply information bits I3..I0 |
| tx_bit | output | 1 | Transmitted line value |
| tx_active | output | 1 | Reply frame on the line |

## Verification
If the receive bit counter drifts by one, the whole request is read one position off. The end bit is then taken from the parity position, so most valid frames disappear from `req_valid` at the end-bit tick, or the wrong fields come out in that same cycle. A wrong gap or reply counter shows up at the ports at the first tick where the start bit or the end bit falls in the wrong place, well before the frame is over. A hold or reply phase that is never left keeps `rsp_ready` high, or silences the next request, within one frame time.

// File: rtl/sbus_codec_pkg.sv
package sbus_codec_pkg;
   // frame overhead: start, control, parity, end (request); start, parity, end (reply)
   localparam int REQ_OVERHEAD = 4;
   localparam int RSP_OVERHEAD = 3;

   typedef enum logic [1:0] {
      PH_LISTEN,
      PH_HOLD,
      PH_REPLY
   } phase_e;
endpackage

// File: rtl/sbus_req_rx.sv
module sbus_req_rx #(
   parameter int ADDR_W = 5,
   parameter int INFO_W = 5,
   localparam int BODY  = ADDR_W + INFO_W + sbus_codec_pkg::REQ_OVERHEAD - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            tick,
   input  logic            rx_bit,
   output logic            done,
   output logic [BODY-1:0] body
);
   localparam int CW = $clog2(BODY);

   logic            active;
   logic [CW-1:0]   cnt;
   logic [BODY-2:0] sh;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
         sh     <= '0;
         done   <= 1'b0;
         body   <= '0;
      end else begin
         done <= 1'b0;
         if (!en) begin
            active <= 1'b0;
            cnt    <= '0;
         end else if (tick) begin
            if (!active) begin
               // a sampled 0 while idle is the start bit
               if (!rx_bit) begin
                  active <= 1'b1;
                  cnt    <= '0;
               end
            end else begin
               sh <= {sh[BODY-3:0], rx_bit};
               if (cnt == CW'(BODY - 1)) begin
                  active <= 1'b0;
                  done   <= 1'b1;
                  body   <= {sh, rx_bit};
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/sbus_rsp_tx.sv
module sbus_rsp_tx #(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] word,
   output logic              tx_bit,
   output logic              busy,
   output logic              done
);
   localparam int LEN = DATA_W + sbus_codec_pkg::RSP_OVERHEAD;
   localparam int CW  = $clog2(LEN);

   logic [LEN-2:0] rest;
   logic [CW-1:0]  cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_bit <= 1'b1;
         busy   <= 1'b0;
         done   <= 1'b0;
         rest   <= '0;
         cnt    <= '0;
      end else begin
         done <= 1'b0;
         if (abort) begin
            tx_bit <= 1'b1;
            busy   <= 1'b0;
            cnt    <= '0;
         end else if (load) begin
            tx_bit <= 1'b0;
            rest   <= {word, ^word, 1'b1};
            cnt    <= CW'(LEN - 1);
            busy   <= 1'b1;
         end else if (tick && busy) begin
            if (cnt == '0) begin
               tx_bit <= 1'b1;
               busy   <= 1'b0;
               done   <= 1'b1;
            end else begin
               tx_bit <= rest[LEN-2];
               rest   <= {rest[LEN-3:0], 1'b1};
               cnt    <= cnt - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sbus_slave_codec.sv
module sbus_slave_codec #(
   parameter int ADDR_W   = 5,
   parameter int INFO_W   = 5,
   parameter int GAP_BITS = 2,
   parameter bit EXT_SEL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inhibit,
   input  logic              ext_mode,
   input  logic [ADDR_W-1:0] my_addr,
   input  logic              my_sel,
   input  logic              tick,
   input  logic              rx_bit,
   output logic              req_valid,
   output logic              req_ctrl,
   output logic [INFO_W-1:0] req_info,
   output logic              rsp_ready,
   input  logic              rsp_valid,
   input  logic [INFO_W-2:0] rsp_info,
   output logic              tx_bit,
   output logic              tx_active
);
   import sbus_codec_pkg::*;

   localparam int BODY    = ADDR_W + INFO_W + REQ_OVERHEAD - 1;
   localparam int RSP_W   = INFO_W - 1;
   localparam int SEL_POS = INFO_W - 2;
   localparam int GAP_W   = $clog2(GAP_BITS + 1);

   initial begin
      assert (GAP_BITS >= 1) else $error("GAP_BITS must be at least 1");
      assert (INFO_W >= 2) else $error("INFO_W must be at least 2");
      assert (ADDR_W >= 1) else $error("ADDR_W must be at least 1");
   end

   phase_e            phase;
   logic [GAP_W-1:0]  gap;
   logic              have;
   logic [RSP_W-1:0]  word;
   logic              rx_done;
   logic [BODY-1:0]   body;
   logic [ADDR_W-1:0] f_addr;
   logic              par_ok, end_ok, match, last_gap;
   logic              tx_load, tx_done;

   sbus_req_rx #(.ADDR_W(ADDR_W), .INFO_W(INFO_W)) i_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (phase == PH_LISTEN && !inhibit),
      .tick   (tick),
      .rx_bit (rx_bit),
      .done   (rx_done),
      .body   (body)
   );

   // body layout, LSB first: end, parity, info, address, control
   assign f_addr   = body[INFO_W+ADDR_W+1 : INFO_W+2];
   assign req_info = body[INFO_W+1 : 2];
   assign req_ctrl = body[BODY-1];
   assign par_ok   = ~^body[BODY-1:1];
   assign end_ok   = body[0];

   generate
      if (EXT_SEL) begin : g_ext
         assign match = (f_addr == my_addr) && (!ext_mode || (req_info[SEL_POS] == my_sel));
      end else begin : g_base
         assign match = (f_addr == my_addr);
      end
   endgenerate

   assign req_valid = rx_done && par_ok && end_ok && match && !inhibit;
   assign last_gap  = tick && (gap == GAP_W'(GAP_BITS - 1));
   assign rsp_ready = (phase == PH_HOLD) && !have && !last_gap && !inhibit;
   assign tx_load   = (phase == PH_HOLD) && last_gap && have && !inhibit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= PH_LISTEN;
         gap   <= '0;
         have  <= 1'b0;
         word  <= '0;
      end else if (inhibit) begin
         phase <= PH_LISTEN;
         gap   <= '0;
         have  <= 1'b0;
      end else begin
         case (phase)
            PH_LISTEN: begin
               if (req_valid) begin
                  phase <= PH_HOLD;
                  gap   <= '0;
                  have  <= 1'b0;
               end
            end
            PH_HOLD: begin
               if (rsp_valid && rsp_ready) begin
                  have <= 1'b1;
                  word <= rsp_info;
               end
               if (last_gap) begin
                  phase <= have ? PH_REPLY : PH_LISTEN;
               end else if (tick) begin
                  gap <= gap + 1'b1;
               end
            end
            PH_REPLY: begin
               if (tx_done) phase <= PH_LISTEN;
            end
            default: phase <= PH_LISTEN;
         endcase
      end
   end

   sbus_rsp_tx #(.DATA_W(RSP_W)) i_tx (
      .clk    (clk),
      .rst_n  (rst_n),
      .abort  (inhibit),
      .tick   (tick),
      .load   (tx_load),
      .word   (word),
      .tx_bit (tx_bit),
      .busy   (tx_active),
      .done   (tx_done)
   );
endmodule

// File: rtl/sbus_codec_chk.sv
module sbus_codec_chk (
   input logic clk,
   input logic rst_n,
   input logic inhibit,
   input logic tick,
   input logic req_valid,
   input logic rsp_ready,
   input logic tx_bit,
   input logic tx_active
);
   // R8
   tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> tx_bit);

   // R8
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !inhibit) |=> $stable(tx_bit));

   // R6
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> !req_valid);

   // R7
   ready_not_sending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_ready |-> !tx_active);

   // R10
   inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inhibit |=> (!tx_active && !rsp_ready && !req_valid));
endmodule

bind sbus_slave_codec sbus_codec_chk i_sbus_codec_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .inhibit   (inhibit),
   .tick      (tick),
   .req_valid (req_valid),
   .rsp_ready (rsp_ready),
   .tx_bit    (tx_bit),
   .tx_active (tx_active)
);

// File: tb/test_sbus_slave_codec.sv
`timescale 1ns/1ps
module test_sbus_slave_codec;
   localparam int GAP = 2;
   localparam logic [4:0] ADDR = 5'h0B;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic inhibit = 1'b0;
   logic ext_mode = 1'b0;
   logic [4:0] my_addr = ADDR;
   logic my_sel = 1'b0;
   logic tick = 1'b0;
   logic rx_bit = 1'b1;
   logic req_valid, req_ctrl, rsp_ready, tx_bit, tx_active;
   logic [4:0] req_info;
   logic rsp_valid = 1'b0;
   logic [3:0] rsp_info = '0;

   int checks = 0;
   int errors = 0;
   int n_req = 0;
   logic cap_ctrl;
   logic [4:0] cap_info;

   always #4 clk = ~clk;

   sbus_slave_codec #(.GAP_BITS(GAP)) i_sbus_slave_codec (
      .clk(clk), .rst_n(rst_n), .inhibit(inhibit), .ext_mode(ext_mode),
      .my_addr(my_addr), .my_sel(my_sel), .tick(tick), .rx_bit(rx_bit),
      .req_valid(req_valid), .req_ctrl(req_ctrl), .req_info(req_info),
      .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_info(rsp_info),
      .tx_bit(tx_bit), .tx_active(tx_active)
   );

   always @(negedge clk) begin
      if (req_valid) begin
         n_req++;
         cap_ctrl = req_ctrl;
         cap_info = req_info;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [13:0] mk(input logic c, input logic [4:0] a, input logic [4:0] i,
                                      input logic flip, input logic eb);
      logic p;
      p = (^{c, a, i}) ^ flip;
      return {1'b0, c, a, i, p, eb};
   endfunction

   task automatic tick_once();
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic send(input logic [13:0] f);
      for (int i = 13; i >= 0; i--) begin
         rx_bit = f[i];
         tick_once();
      end
      rx_bit = 1'b1;
   endtask

   task automatic reply(input logic [3:0] w, input string tag);
      logic [6:0] exp;
      check(rsp_ready === 1'b1, {tag, " R7 ready"}, rsp_ready, 1);
      rsp_valid = 1'b1;
      rsp_info  = w;
      @(negedge clk);
      rsp_valid = 1'b0;
      check(rsp_ready === 1'b0, {tag, " R7 ready drop"}, rsp_ready, 0);
      for (int g = 1; g < GAP; g++) begin
         tick_once();
         check(tx_active === 1'b0 && tx_bit === 1'b1, {tag, " R8 gap idle"}, {tx_active, tx_bit}, 1);
      end
      exp = {1'b0, w, ^w, 1'b1};
      for (int b = 6; b >= 0; b--) begin
         tick_once();
         check(tx_bit === exp[b] && tx_active === 1'b1, {tag, " R8 reply bit"}, {tx_active, tx_bit}, {1'b1, exp[b]});
      end
      tick_once();
      check(tx_active === 1'b0 && tx_bit === 1'b1, {tag, " R8 reply end"}, {tx_active, tx_bit}, 1);
   endtask

   task automatic expect_req(input logic [13:0] f, input int n0, input string tag);
      check(n_req == n0 + 1, {tag, " R6 one pulse"}, n_req - n0, 1);
      check(cap_ctrl === f[12] && cap_info === f[6:2], {tag, " R6 fields"}, {cap_ctrl, cap_info}, {f[12], f[6:2]});
   endtask

   task automatic expect_silent(input logic [13:0] f, input string tag);
      int n0;
      n0 = n_req;
      send(f);
      check(n_req == n0, {tag, " no req"}, n_req - n0, 0);
      check(rsp_ready === 1'b0, {tag, " no ready"}, rsp_ready, 0);
      for (int k = 0; k < GAP + 2; k++) begin
         tick_once();
         check(tx_active === 1'b0, {tag, " no reply"}, tx_active, 0);
      end
   endtask

   task automatic full_txn(input logic [13:0] f, input logic [3:0] w, input string tag);
      int n0;
      n0 = n_req;
      send(f);
      expect_req(f, n0, tag);
      reply(w, tag);
   endtask

   task automatic t_reset();
      check(tx_bit === 1'b1 && tx_active === 1'b0, "R8 reset line", {tx_active, tx_bit}, 1);
      check(req_valid === 1'b0 && rsp_ready === 1'b0, "R6 reset outputs", {req_valid, rsp_ready}, 0);
   endtask

   task automatic t_data_req();   // R1, R4: data transfer, idle ones first
      for (int k = 0; k < 3; k++) tick_once();
      full_txn(mk(1'b0, ADDR, 5'h15, 1'b0, 1'b1), 4'hA, "R1 data");
      full_txn(mk(1'b0, ADDR, 5'h03, 1'b0, 1'b1), 4'h7, "R4 data2");
   endtask

   task automatic t_cmd_req();
      full_txn(mk(1'b1, ADDR, 5'h1F, 1'b0, 1'b1), 4'h1, "R6 command");
   endtask

   task automatic t_addr_miss();
      expect_silent(mk(1'b0, 5'h0A, 5'h04, 1'b0, 1'b1), "R4 miss");
   endtask

   task automatic t_bad_parity();
      expect_silent(mk(1'b0, ADDR, 5'h04, 1'b1, 1'b1), "R2 parity");
   endtask

   task automatic t_bad_end();
      expect_silent(mk(1'b0, ADDR, 5'h04, 1'b0, 1'b0), "R3 end");
   endtask

   task automatic t_ext_sel();
      ext_mode = 1'b1;
      my_sel   = 1'b1;
      full_txn(mk(1'b0, ADDR, 5'h08, 1'b0, 1'b1), 4'h5, "R5 B match");
      expect_silent(mk(1'b0, ADDR, 5'h00, 1'b0, 1'b1), "R5 A miss");
      ext_mode = 1'b0;
      full_txn(mk(1'b0, ADDR, 5'h00, 1'b0, 1'b1), 4'hC, "R4 sel ignored");
      my_sel = 1'b0;
   endtask

   task automatic t_no_word();
      int n0;
      n0 = n_req;
      send(mk(1'b0, ADDR, 5'h11, 1'b0, 1'b1));
      check(n_req == n0 + 1, "R9 request seen", n_req - n0, 1);
      for (int k = 0; k < GAP + 1; k++) begin
         tick_once();
         check(tx_active === 1'b0, "R9 no reply", tx_active, 0);
      end
      check(rsp_ready === 1'b0, "R9 ready dropped", rsp_ready, 0);
      full_txn(mk(1'b1, ADDR, 5'h02, 1'b0, 1'b1), 4'h3, "R9 next frame");
   endtask

   task automatic t_inhibit_rx();
      logic [13:0] f;
      int n0;
      f  = mk(1'b0, ADDR, 5'h06, 1'b0, 1'b1);
      n0 = n_req;
      for (int i = 13; i >= 8; i--) begin
         rx_bit = f[i];
         tick_once();
      end
      inhibit = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         rx_bit = f[i];
         tick_once();
      end
      rx_bit  = 1'b1;
      inhibit = 1'b0;
      check(n_req == n0, "R10 partial dropped", n_req - n0, 0);
      full_txn(mk(1'b0, ADDR, 5'h19, 1'b0, 1'b1), 4'h9, "R10 after inhibit");
   endtask

   task automatic t_inhibit_tx();
      send(mk(1'b0, ADDR, 5'h0C, 1'b0, 1'b1));
      rsp_valid = 1'b1;
      rsp_info  = 4'h0;
      @(negedge clk);
      rsp_valid = 1'b0;
      for (int k = 0; k < GAP + 1; k++) tick_once();
      check(tx_active === 1'b1, "R8 sending before inhibit", tx_active, 1);
      inhibit = 1'b1;
      @(negedge clk);
      check(tx_active === 1'b0 && tx_bit === 1'b1, "R10 reply stopped", {tx_active, tx_bit}, 1);
      check(rsp_ready === 1'b0, "R10 ready low", rsp_ready, 0);
      inhibit = 1'b0;
      for (int k = 0; k < 4; k++) begin
         tick_once();
         check(tx_active === 1'b0 && tx_bit === 1'b1, "R10 stays idle", {tx_active, tx_bit}, 1);
      end
      full_txn(mk(1'b0, ADDR, 5'h1A, 1'b0, 1'b1), 4'hF, "R10 resume");
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_data_req();
      t_cmd_req();
      t_addr_miss();
      t_bad_parity();
      t_bad_end();
      t_ext_sel();
      t_no_word();
      t_inhibit_rx();
      t_inhibit_tx();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule